// File: doc/BRIEF.md
# Variable-Oversampling UART Bit-Timing Generator

This block produces the bit-timing strobes for a 16550-style serial port whose oversampling ratio is selectable. A 16-bit divisor cuts the UART clock down to a divided tick. A phase counter numbers the ticks inside each bit. The block raises a receive sample strobe on a chosen tick and a bit-boundary strobe on the last tick of every bit. A speed-mode register sets the ratio to 16, 8 or 4 ticks per bit. A fourth, programmable mode takes the bit length and the sample position from two byte registers.

Configuration goes through a byte-wide, word-addressed register port. The divisor bytes share offsets 0 and 1 with the data and interrupt-enable registers of the surrounding UART. This block therefore keeps a copy of the line-control register and honours the divisor-latch-access bit (bit 7) in it. The receiver pulses `restart` when it sees a start-bit edge, so that the sample strobe lines up with the incoming bit. Writing the divisor or the speed mode also restarts the counters.

The port has no streaming data path. Every pin is a plain control pin or a one-cycle strobe, and none of them has back-pressure. A write is taken on any rising edge where `reg_we` is high. `reg_rdata` reflects `reg_addr` combinationally.

Top module: `baud_gen_os`

## Requirements
- R1: After reset the speed mode reads 0, sample count 0x00, sample point 0xFF, line control 0x00, rate-fix 0x00 and both divisor bytes 0x00.
- R2: Register offsets are: divisor low byte 0x0 and high byte 0x1 (both only while line-control bit 7 is set), line control 0x3, speed mode 0x9 (bits 1:0), sample count 0xA, sample point 0xB and rate-fix 0xD. Each reads back what was written. Any other offset reads 0.
- R3: While line-control bit 7 is clear, writes to offsets 0x0 and 0x1 leave the divisor unchanged, and reads of them return 0.
- R4: `tick` fires once every D clock cycles, where D is the divisor. A divisor of 0 acts as 1.
- R5: A bit spans 16 ticks in speed mode 0, 8 in mode 1, 4 in mode 2 and (sample count + 1) in mode 3.
- R6: In modes 0 to 2 `sample_stb` fires together with `tick` on the tick whose index within the bit equals half the ticks per bit.
- R7: In mode 3 `sample_stb` fires on the tick whose index equals the sample-point value. If that value is larger than the sample count, it never fires.
- R8: `bit_end` fires together with `tick` on the last tick index of each bit, and the next tick is index 0.
- R9: A `restart` pulse clears both counters. The first tick after it comes D-1 cycles after the clearing edge, and that tick is index 0.
- R10: A write to either divisor byte (while bit 7 is set) or to the speed mode clears the counters exactly as `restart` does.
- R11: The rate-fix register has no effect on any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word offset of the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| restart | input | 1 | One-cycle counter clear for start-bit alignment |
| tick | output | 1 | Divided tick strobe |
| sample_stb | output | 1 | Receive sample strobe |
| bit_end | output | 1 | Last tick of the current bit |

## Verification
The strobes are compared cycle by cycle, starting from a counter clear, against a model built from the divisor and the mode. The directed patterns are:
- A divisor of 0 against a divisor of 1, which tells the zero guard apart from a wrapped prescaler.
- Each fixed mode, which tells a mistaken ratio or midpoint apart from a correct one.
- Mode 3 with a count of 0, and with sample points inside, at the edge of and past the bit, which tells an exact index match apart from an off-by-one.

A restart in mid-bit, a mode write used as the clear, and a non-zero rate-fix value check that the counters really realign and that rate-fix does nothing. Seeded random settings of divisor, mode, count and point then cover combinations that the directed cases miss.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam logic [3:0] OFF_DIV_LO = 4'h0;
  localparam logic [3:0] OFF_DIV_HI = 4'h1;
  localparam logic [3:0] OFF_LINE   = 4'h3;
  localparam logic [3:0] OFF_SPEED  = 4'h9;
  localparam logic [3:0] OFF_SCOUNT = 4'hA;
  localparam logic [3:0] OFF_SPOINT = 4'hB;
  localparam logic [3:0] OFF_RFIX   = 4'hD;
  localparam int         LATCH_BIT  = 7;

  typedef enum logic [1:0] {
    SPD_X16  = 2'd0,
    SPD_X8   = 2'd1,
    SPD_X4   = 2'd2,
    SPD_PROG = 2'd3
  } speed_e;
endpackage

// File: rtl/bg_regs.sv
module bg_regs
  import baud_gen_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [3:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DIV_W-1:0]  divisor,
  output speed_e            speed,
  output logic [DATA_W-1:0] scount,
  output logic [DATA_W-1:0] spoint,
  output logic              cfg_clear
);
  localparam int HI_W = DIV_W - DATA_W;

  logic [DATA_W-1:0] line_q, rfix_q, div_lo_q;
  logic [HI_W-1:0]   div_hi_q;
  logic              latch_open;

  assign latch_open = line_q[LATCH_BIT];
  assign divisor    = {div_hi_q, div_lo_q};

  // The counters restart whenever the timing base itself changes.
  assign cfg_clear = we && ((addr == OFF_SPEED) ||
                     (latch_open && (addr == OFF_DIV_LO || addr == OFF_DIV_HI)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q   <= '0;
      rfix_q   <= '0;
      div_lo_q <= '0;
      div_hi_q <= '0;
      speed    <= SPD_X16;
      scount   <= '0;
      spoint   <= '1;
    end else if (we) begin
      case (addr)
        OFF_DIV_LO: if (latch_open) div_lo_q <= wdata;
        OFF_DIV_HI: if (latch_open) div_hi_q <= wdata[HI_W-1:0];
        OFF_LINE:   line_q <= wdata;
        OFF_SPEED:  speed  <= speed_e'(wdata[1:0]);
        OFF_SCOUNT: scount <= wdata;
        OFF_SPOINT: spoint <= wdata;
        OFF_RFIX:   rfix_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_DIV_LO: if (latch_open) rdata = div_lo_q;
      OFF_DIV_HI: if (latch_open) rdata = DATA_W'(div_hi_q);
      OFF_LINE:   rdata = line_q;
      OFF_SPEED:  rdata = DATA_W'(speed);
      OFF_SCOUNT: rdata = scount;
      OFF_SPOINT: rdata = spoint;
      OFF_RFIX:   rdata = rfix_q;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/bg_prescale.sv
module bg_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, limit;

  // A divisor of zero behaves as one: the limit stays at zero.
  assign limit = (divisor == '0) ? '0 : divisor - DIV_W'(1);
  assign tick  = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/bg_phase.sv
module bg_phase
  import baud_gen_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PH_W   = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              tick,
  input  speed_e            speed,
  input  logic [DATA_W-1:0] scount,
  input  logic [DATA_W-1:0] spoint,
  output logic [PH_W-1:0]   phase,
  output logic              sample_stb,
  output logic              bit_end
);
  logic [PH_W-1:0] last_idx, samp_idx;

  always_comb begin
    case (speed)
      SPD_X16: begin last_idx = PH_W'(15); samp_idx = PH_W'(8); end
      SPD_X8:  begin last_idx = PH_W'(7);  samp_idx = PH_W'(4); end
      SPD_X4:  begin last_idx = PH_W'(3);  samp_idx = PH_W'(2); end
      default: begin last_idx = PH_W'(scount); samp_idx = PH_W'(spoint); end
    endcase
  end

  assign sample_stb = tick && (phase == samp_idx);
  // >= keeps the bit bounded if the count shrinks under a running phase.
  assign bit_end    = tick && (phase >= last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (clear)   phase <= '0;
    else if (bit_end) phase <= '0;
    else if (tick)    phase <= phase + PH_W'(1);
  end
endmodule

// File: rtl/baud_gen_os.sv
module baud_gen_os
  import baud_gen_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              restart,
  output logic              tick,
  output logic              sample_stb,
  output logic              bit_end
);
  localparam int PH_W = DATA_W + 1;

  logic [DIV_W-1:0]  divisor;
  speed_e            speed;
  logic [DATA_W-1:0] scount, spoint;
  logic              cfg_clear, ctr_clear;
  logic [PH_W-1:0]   phase;

  assign ctr_clear = restart || cfg_clear;

  bg_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .divisor(divisor), .speed(speed), .scount(scount),
    .spoint(spoint), .cfg_clear(cfg_clear)
  );

  bg_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(ctr_clear), .divisor(divisor), .tick(tick)
  );

  bg_phase #(.DATA_W(DATA_W), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .clear(ctr_clear), .tick(tick), .speed(speed),
    .scount(scount), .spoint(spoint), .phase(phase),
    .sample_stb(sample_stb), .bit_end(bit_end)
  );
endmodule

// File: rtl/bg_checker.sv
module bg_checker
  import baud_gen_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  parameter int PH_W   = DATA_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [3:0]        reg_addr,
  input logic              ctr_clear,
  input logic              tick,
  input logic              sample_stb,
  input logic              bit_end,
  input logic [DIV_W-1:0]  divisor,
  input speed_e            speed,
  input logic [DATA_W-1:0] scount,
  input logic [DATA_W-1:0] spoint,
  input logic [PH_W-1:0]   phase
);
  assert_sample_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> tick);

  assert_bitend_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> tick);

  assert_wrap_after_bitend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> (phase == '0));

  assert_clear_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_clear |=> (phase == '0));

  assert_clear_no_early_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_clear |=> (divisor <= DIV_W'(1) || !tick));

  assert_mode_write_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFF_SPEED) |=> (phase == '0));

  assert_point_past_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (speed == SPD_PROG && spoint > scount) |-> !sample_stb);
endmodule

bind baud_gen_os bg_checker #(.DIV_W(DIV_W), .DATA_W(DATA_W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .ctr_clear(ctr_clear), .tick(tick), .sample_stb(sample_stb), .bit_end(bit_end),
  .divisor(divisor), .speed(speed), .scount(scount), .spoint(spoint), .phase(phase)
);

// File: tb/baud_gen_os_test.sv
module baud_gen_os_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       restart = 1'b0;
  logic       tick, sample_stb, bit_end;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  baud_gen_os uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .restart(restart),
    .tick(tick), .sample_stb(sample_stb), .bit_end(bit_end)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic pulse_restart();
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  function automatic int tpb_of(input int mode, input int sc);
    case (mode)
      0: return 16;
      1: return 8;
      2: return 4;
      default: return sc + 1;
    endcase
  endfunction

  function automatic int sidx_of(input int mode, input int sp);
    if (mode == 3) return sp;
    return tpb_of(mode, 0) / 2;
  endfunction

  // Called in the first cycle after a counter clear; compares every cycle.
  task automatic measure(input int div, input int mode, input int sc, input int sp,
                         input int nbits, input string tag);
    int d = (div == 0) ? 1 : div;
    int tpb = tpb_of(mode, sc);
    int sidx = sidx_of(mode, sp);
    int len = nbits * tpb * d;
    int bad_t = 0, bad_s = 0, bad_b = 0, n_s = 0, n_b = 0;
    for (int c = 0; c < len; c++) begin
      bit et = ((c + 1) % d) == 0;
      int ph = ((c + 1) / d - 1) % tpb;
      bit es = et && (ph == sidx);
      bit eb = et && (ph == tpb - 1);
      if (tick !== et) bad_t++;
      if (sample_stb !== es) bad_s++;
      if (bit_end !== eb) bad_b++;
      if (sample_stb === 1'b1) n_s++;
      if (bit_end === 1'b1) n_b++;
      @(negedge clk);
    end
    check(bad_t == 0, {"R4 tick cadence ", tag}, bad_t, 0);
    check(bad_s == 0, {(mode == 3) ? "R7" : "R6", " sample strobe ", tag}, n_s,
          (sidx < tpb) ? nbits : 0);
    check(bad_b == 0, {"R5 R8 bit length ", tag}, n_b, nbits);
  endtask

  task automatic config_run(input int div, input int mode, input int sc, input int sp,
                            input int nbits, input string tag);
    wr(4'h3, 8'h80);
    wr(4'h0, div[7:0]);
    wr(4'h1, div[15:8]);
    wr(4'h3, 8'h00);
    wr(4'hA, sc[7:0]);
    wr(4'hB, sp[7:0]);
    wr(4'h9, mode[7:0]);
    pulse_restart();
    measure(div, mode, sc, sp, nbits, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'h9, v); check(v == 8'h00, "R1 speed reset", v, 0);
    rd(4'hA, v); check(v == 8'h00, "R1 count reset", v, 0);
    rd(4'hB, v); check(v == 8'hFF, "R1 point reset", v, 255);
    rd(4'h3, v); check(v == 8'h00, "R1 line reset", v, 0);
    rd(4'hD, v); check(v == 8'h00, "R1 ratefix reset", v, 0);
    wr(4'h3, 8'h80);
    rd(4'h0, v); check(v == 8'h00, "R1 divisor low reset", v, 0);
    rd(4'h1, v); check(v == 8'h00, "R1 divisor high reset", v, 0);

    // R2 readback and unused offset
    wr(4'h0, 8'h5A); wr(4'h1, 8'hC3);
    rd(4'h0, v); check(v == 8'h5A, "R2 divisor low", v, 'h5A);
    rd(4'h1, v); check(v == 8'hC3, "R2 divisor high", v, 'hC3);
    wr(4'hA, 8'h21); rd(4'hA, v); check(v == 8'h21, "R2 count", v, 'h21);
    wr(4'h9, 8'h02); rd(4'h9, v); check(v == 8'h02, "R2 speed", v, 2);
    rd(4'h5, v); check(v == 8'h00, "R2 unused offset", v, 0);

    // R3 divisor closed while latch bit clear
    wr(4'h3, 8'h03);
    rd(4'h0, v); check(v == 8'h00, "R3 closed read", v, 0);
    wr(4'h0, 8'h11); wr(4'h1, 8'h22);
    wr(4'h3, 8'h83);
    rd(4'h0, v); check(v == 8'h5A, "R3 low kept", v, 'h5A);
    rd(4'h1, v); check(v == 8'hC3, "R3 high kept", v, 'hC3);
    wr(4'h3, 8'h00);

    // Directed timing cases
    config_run(0, 2, 0, 255, 3, "div0 as 1");
    config_run(1, 2, 0, 255, 3, "div1");
    config_run(3, 0, 0, 255, 2, "mode0 div3");
    config_run(2, 1, 0, 255, 3, "mode1 div2");
    config_run(1, 3, 0, 0, 4, "R7 count0 point0");
    config_run(2, 3, 9, 4, 3, "R7 point centre");
    config_run(1, 3, 9, 9, 3, "R7 point at last");
    config_run(1, 3, 9, 10, 3, "R7 point past count");
    config_run(1, 3, 5, 255, 3, "R7 point ff");

    // R9 restart in mid-bit
    repeat (7) @(negedge clk);
    pulse_restart();
    measure(1, 3, 5, 255, 2, "R9 mid-bit restart");

    // R10 mode write acts as the clear
    repeat (5) @(negedge clk);
    wr(4'h9, 8'h01);
    measure(1, 1, 5, 255, 2, "R10 mode write clear");
    repeat (3) @(negedge clk);
    wr(4'h3, 8'h80);
    repeat (4) @(negedge clk);
    wr(4'h0, 8'h03);
    measure(3, 1, 5, 255, 2, "R10 divisor write clear");
    wr(4'h3, 8'h00);

    // R11 rate-fix has no effect
    wr(4'hD, 8'hFF);
    config_run(2, 2, 0, 255, 3, "R11 ratefix set");
    rd(4'hD, v); check(v == 8'hFF, "R11 ratefix readback", v, 255);
    wr(4'hD, 8'h00);

    // Seeded random configurations
    for (int i = 0; i < 24; i++) begin
      int div = $urandom_range(0, 5);
      int mode = $urandom_range(0, 3);
      int sc = $urandom_range(0, 40);
      int sp = ($urandom_range(0, 3) == 0) ? 255 : $urandom_range(0, 42);
      config_run(div, mode, sc, sp, 2, $sformatf("rand%0d", i));
    end

    finish_run();
  end
endmodule